// File: doc/BRIEF.md
# MAC control and status register file

This block holds the configuration and status words of an Ethernet MAC. Software reaches it over a word-aligned 32-bit read/write bus. The descriptor engines and the management serial engine only read its outputs. Each plain register drives an output port directly. The station address comes out as one 48-bit vector and the two hash words as one 64-bit vector.

Event inputs latch bits into an interrupt source register. Software clears those bits by writing ones to them. A single level interrupt is formed from the source bits that are enabled by the mask register. A window of the address space maps a descriptor RAM, which the descriptor engines read through a second read port.

Writing the descriptor split count also reloads the receive descriptor index, which is kept in the block. Misaligned accesses and accesses to offsets that decode to nothing are refused and flagged.

Top module: `mac_csr_bank`

## Requirements
- R1: After reset the registers hold these values: mode 0x0000A000, transmit gap 0x12, receive gap 1 0x0C, receive gap 2 0x12, frame length 0x003C0600, collision setting 0x000F003F, split count 0x80, management mode 0x64. Every other register and the interrupt source read 0. The receive descriptor index is 0x80 and `irq_o` is low.
- R2: A write to the interrupt source register (offset 0x04) clears each source bit whose data bit is 1 and leaves the other source bits as they were.
- R3: A 1 on an `evt_i` bit sets the matching source bit at the next clock edge. If that bit is being cleared by a write in the same cycle, the bit still ends up set.
- R4: `irq_o` is high exactly when some interrupt source bit and the same bit of the mask register (offset 0x08, low IRQ_W bits stored) are both 1.
- R5: A write to the split count register (offset 0x20) stores only data bits 7:0. It also loads the receive descriptor index `rx_bd_idx_o` with the same 8 bits.
- R6: Station register low (offset 0x40) holds address byte 3 in bits 31:24, byte 2 in bits 23:16, byte 1 in bits 15:8 and byte 0 in bits 7:0. Station register high (offset 0x44) holds byte 5 in bits 15:8 and byte 4 in bits 7:0, and its upper bits read 0. `station_o` carries byte k in bits 8k+7:8k.
- R7: An aligned access to address BD_BASE + 4·n, with n below BD_WORDS, reads or writes descriptor word n. `bd_rd_data_o` returns word `bd_rd_idx_i` combinationally.
- R8: An access whose address has bits 1:0 not equal to 0 changes no state. Its response data is 0 and `rsp_err_o` pulses in the following cycle.
- R9: An aligned access to an address that is neither a register nor a descriptor word changes no state. Its response data is 0 and `rsp_err_o` pulses in the following cycle.
- R10: The registers sit at offset 4·k in this order: mode, interrupt source, mask, transmit gap, receive gap 1, receive gap 2, frame length, collision setting, split count, control mode, management mode, management command, management address, management write data, management read data, management status, station low, station high, hash low, hash high. Every register not named above stores all 32 bits. Read data appears on `rsp_rdata_o` in the cycle after the request. In a cycle with no read response, `rsp_rdata_o` is 0 and `rsp_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after request |
| rsp_err_o | output | 1 | Refused access, one cycle after request |
| evt_i | input | IRQ_W | Interrupt events |
| bd_rd_idx_i | input | log2(BD_WORDS) | Engine descriptor word index |
| bd_rd_data_o | output | 32 | Engine descriptor word |
| mode_o | output | 32 | Mode register |
| ipg_tx_o | output | 32 | Transmit gap |
| ipg_rx1_o | output | 32 | Receive gap 1 |
| ipg_rx2_o | output | 32 | Receive gap 2 |
| frame_len_o | output | 32 | Frame length limits |
| coll_cfg_o | output | 32 | Collision setting |
| split_o | output | SPLIT_W | Descriptor split count |
| rx_bd_idx_o | output | SPLIT_W | Receive descriptor index |
| ctrl_mode_o | output | 32 | Control mode |
| mgmt_mode_o | output | 32 | Management mode |
| mgmt_cmd_o | output | 32 | Management command |
| mgmt_addr_o | output | 32 | Management address |
| mgmt_wdata_o | output | 32 | Management write data |
| mgmt_rdata_o | output | 32 | Management read data register |
| mgmt_stat_o | output | 32 | Management status register |
| station_o | output | 48 | Station address, byte k at 8k |
| hash_o | output | 64 | {hash high, hash low} |
| irq_src_o | output | IRQ_W | Interrupt source bits |
| irq_o | output | 1 | Masked interrupt |

## Verification
The write-one-to-clear path is tried with every 7-bit clear pattern against a fully set source register. This separates a true per-bit clear from a whole-register clear and from a plain store. A write to clear that coincides with an event shows which of the two wins. Sweeping all 128 mask values against an alternating source pattern tells an AND-OR interrupt apart from an OR of the mask or an OR of the source alone. Every register and descriptor word is written with a distinct pattern and read back, which exposes swapped decodes and truncated widths. Misaligned and out-of-map addresses are then followed by a full readback, to show that they left no trace.

// File: rtl/mac_csr_pkg.sv
`timescale 1ns/1ps
package mac_csr_pkg;

   localparam int unsigned CSR_DW  = 32;
   localparam int unsigned NUM_CSR = 20;

   // register slot = byte offset / 4
   typedef enum logic [4:0] {
      CSR_MODE       = 5'd0,
      CSR_IRQ_SRC    = 5'd1,
      CSR_IRQ_MASK   = 5'd2,
      CSR_IPG_TX     = 5'd3,
      CSR_IPG_RX1    = 5'd4,
      CSR_IPG_RX2    = 5'd5,
      CSR_FRAME_LEN  = 5'd6,
      CSR_COLL       = 5'd7,
      CSR_SPLIT      = 5'd8,
      CSR_CTRL       = 5'd9,
      CSR_MGMT_MODE  = 5'd10,
      CSR_MGMT_CMD   = 5'd11,
      CSR_MGMT_ADDR  = 5'd12,
      CSR_MGMT_WDATA = 5'd13,
      CSR_MGMT_RDATA = 5'd14,
      CSR_MGMT_STAT  = 5'd15,
      CSR_STN_LO     = 5'd16,
      CSR_STN_HI     = 5'd17,
      CSR_HASH_LO    = 5'd18,
      CSR_HASH_HI    = 5'd19
   } csr_idx_e;

   function automatic logic [CSR_DW-1:0] csr_reset_val(int unsigned idx);
      logic [CSR_DW-1:0] v;
      v = '0;
      if (idx == int'(CSR_MODE))      v = 32'h0000_A000;
      if (idx == int'(CSR_IPG_TX))    v = 32'h0000_0012;
      if (idx == int'(CSR_IPG_RX1))   v = 32'h0000_000C;
      if (idx == int'(CSR_IPG_RX2))   v = 32'h0000_0012;
      if (idx == int'(CSR_FRAME_LEN)) v = 32'h003C_0600;
      if (idx == int'(CSR_COLL))      v = 32'h000F_003F;
      if (idx == int'(CSR_SPLIT))     v = 32'h0000_0080;
      if (idx == int'(CSR_MGMT_MODE)) v = 32'h0000_0064;
      return v;
   endfunction

   function automatic logic [CSR_DW-1:0] csr_store_mask(int unsigned idx,
                                                        int unsigned irq_w,
                                                        int unsigned split_w);
      logic [CSR_DW-1:0] m;
      m = '1;
      if (idx == int'(CSR_IRQ_MASK)) m = CSR_DW'((64'd1 << irq_w) - 64'd1);
      if (idx == int'(CSR_SPLIT))    m = CSR_DW'((64'd1 << split_w) - 64'd1);
      if (idx == int'(CSR_STN_HI))   m = 32'h0000_FFFF;
      return m;
   endfunction

endpackage

// File: rtl/mac_csr_decode.sv
`timescale 1ns/1ps
module mac_csr_decode #(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned BD_BASE  = 32'h400,
   parameter int unsigned BD_WORDS = 64,
   localparam int unsigned BD_AW   = $clog2(BD_WORDS)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              aligned_o,
   output logic              reg_hit_o,
   output logic [4:0]        reg_idx_o,
   output logic              bd_hit_o,
   output logic [BD_AW-1:0]  bd_idx_o
);
   import mac_csr_pkg::*;

   localparam int unsigned WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] REG_LIMIT = WORD_W'(NUM_CSR);
   localparam logic [WORD_W-1:0] BD_LO     = WORD_W'(BD_BASE / 4);
   localparam logic [WORD_W-1:0] BD_HI_M1  = WORD_W'(BD_BASE / 4 + BD_WORDS - 1);

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] bd_off;

   assign word      = addr_i[ADDR_W-1:2];
   assign aligned_o = (addr_i[1:0] == 2'b00);
   assign reg_hit_o = aligned_o && (word < REG_LIMIT);
   assign reg_idx_o = word[4:0];
   assign bd_off    = word - BD_LO;
   assign bd_hit_o  = aligned_o && (word >= BD_LO) && (word <= BD_HI_M1);
   assign bd_idx_o  = bd_off[BD_AW-1:0];

endmodule

// File: rtl/mac_csr_irq.sv
`timescale 1ns/1ps
module mac_csr_irq #(
   parameter int unsigned IRQ_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] evt_i,
   input  logic             clr_en_i,
   input  logic [IRQ_W-1:0] clr_data_i,
   input  logic [IRQ_W-1:0] mask_i,
   output logic [IRQ_W-1:0] src_o,
   output logic             irq_o
);
   logic [IRQ_W-1:0] src_q;
   logic [IRQ_W-1:0] clr_bits;

   assign clr_bits = clr_en_i ? clr_data_i : '0;

   // set has priority: OR the events after the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= (src_q & ~clr_bits) | evt_i;
   end

   assign src_o = src_q;
   assign irq_o = |(src_q & mask_i);

   assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && evt_i == '0) |=> ((src_o & $past(clr_data_i)) == '0));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_en_i && evt_i == '0) |=> (src_o == $past(src_o)));

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((src_o & $past(evt_i)) == $past(evt_i)));

   assert_mask_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i == '0) |-> !irq_o);

endmodule

// File: rtl/mac_csr_bdram.sv
`timescale 1ns/1ps
module mac_csr_bdram #(
   parameter int unsigned WORDS = 64,
   parameter int unsigned DW    = 32,
   localparam int unsigned AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_a_i,
   output logic [DW-1:0] rdata_a_o,
   input  logic [AW-1:0] raddr_b_i,
   output logic [DW-1:0] rdata_b_o
);
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_a_o = mem[raddr_a_i];
   assign rdata_b_o = mem[raddr_b_i];

endmodule

// File: rtl/mac_csr_bank.sv
`timescale 1ns/1ps
module mac_csr_bank #(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned BD_BASE  = 32'h400,
   parameter int unsigned BD_WORDS = 64,
   parameter int unsigned IRQ_W    = 7,
   parameter int unsigned SPLIT_W  = 8,
   localparam int unsigned BD_AW   = $clog2(BD_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [31:0]        req_wdata_i,
   output logic [31:0]        rsp_rdata_o,
   output logic               rsp_err_o,
   input  logic [IRQ_W-1:0]   evt_i,
   input  logic [BD_AW-1:0]   bd_rd_idx_i,
   output logic [31:0]        bd_rd_data_o,
   output logic [31:0]        mode_o,
   output logic [31:0]        ipg_tx_o,
   output logic [31:0]        ipg_rx1_o,
   output logic [31:0]        ipg_rx2_o,
   output logic [31:0]        frame_len_o,
   output logic [31:0]        coll_cfg_o,
   output logic [SPLIT_W-1:0] split_o,
   output logic [SPLIT_W-1:0] rx_bd_idx_o,
   output logic [31:0]        ctrl_mode_o,
   output logic [31:0]        mgmt_mode_o,
   output logic [31:0]        mgmt_cmd_o,
   output logic [31:0]        mgmt_addr_o,
   output logic [31:0]        mgmt_wdata_o,
   output logic [31:0]        mgmt_rdata_o,
   output logic [31:0]        mgmt_stat_o,
   output logic [47:0]        station_o,
   output logic [63:0]        hash_o,
   output logic [IRQ_W-1:0]   irq_src_o,
   output logic               irq_o
);
   import mac_csr_pkg::*;

   localparam logic [SPLIT_W-1:0] RX_IDX_RST =
      SPLIT_W'(csr_reset_val(int'(CSR_SPLIT)));
   localparam logic [ADDR_W-1:0] SPLIT_ADDR = ADDR_W'(int'(CSR_SPLIT) * 4);

   // ---------------- elaboration checks ----------------
   if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_aw
      $error("ADDR_W must lie in 7..32");
   end
   if (BD_BASE % 4 != 0 || BD_BASE < NUM_CSR * 4) begin : g_bad_base
      $error("BD_BASE must be word aligned and above the register slots");
   end
   if (BD_WORDS < 2 || (BD_WORDS & (BD_WORDS - 1)) != 0) begin : g_bad_words
      $error("BD_WORDS must be a power of two of at least 2");
   end
   if (64'(BD_BASE) + 64'(BD_WORDS) * 4 > (64'd1 << ADDR_W)) begin : g_bad_fit
      $error("descriptor window does not fit the address space");
   end
   if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irq
      $error("IRQ_W must lie in 1..32");
   end
   if (SPLIT_W < 8 || SPLIT_W > 32) begin : g_bad_split
      $error("SPLIT_W must lie in 8..32");
   end

   // ---------------- decode ----------------
   logic             aligned, reg_hit, bd_hit;
   logic [4:0]       reg_idx;
   logic [BD_AW-1:0] bd_idx;

   mac_csr_decode #(
      .ADDR_W   (ADDR_W),
      .BD_BASE  (BD_BASE),
      .BD_WORDS (BD_WORDS)
   ) u_decode (
      .addr_i    (req_addr_i),
      .aligned_o (aligned),
      .reg_hit_o (reg_hit),
      .reg_idx_o (reg_idx),
      .bd_hit_o  (bd_hit),
      .bd_idx_o  (bd_idx)
   );

   logic wr_reg, wr_bd;
   assign wr_reg = req_valid_i && req_write_i && reg_hit;
   assign wr_bd  = req_valid_i && req_write_i && bd_hit;

   // ---------------- plain registers ----------------
   logic [31:0]      csr_q [NUM_CSR];
   logic [IRQ_W-1:0] irq_src;

   for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
      localparam logic [31:0] MASK = csr_store_mask(i, IRQ_W, SPLIT_W);
      localparam logic [31:0] RST  = csr_reset_val(i) & MASK;
      if (i == int'(CSR_IRQ_SRC)) begin : g_src
         assign csr_q[i] = 32'(irq_src);
      end else begin : g_store
         logic [31:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= RST;
            else if (wr_reg && reg_idx == 5'(i)) q <= req_wdata_i & MASK;
         end
         assign csr_q[i] = q;
      end
   end

   // ---------------- receive descriptor index ----------------
   logic [SPLIT_W-1:0] rx_idx_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_idx_q <= RX_IDX_RST;
      else if (wr_reg && reg_idx == CSR_SPLIT) rx_idx_q <= req_wdata_i[SPLIT_W-1:0];
   end

   // ---------------- interrupt ----------------
   mac_csr_irq #(.IRQ_W(IRQ_W)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_en_i   (wr_reg && reg_idx == CSR_IRQ_SRC),
      .clr_data_i (req_wdata_i[IRQ_W-1:0]),
      .mask_i     (csr_q[CSR_IRQ_MASK][IRQ_W-1:0]),
      .src_o      (irq_src),
      .irq_o      (irq_o)
   );

   // ---------------- descriptor RAM ----------------
   logic [31:0] bd_bus_rdata;

   mac_csr_bdram #(.WORDS(BD_WORDS), .DW(32)) u_bdram (
      .clk       (clk),
      .we_i      (wr_bd),
      .waddr_i   (bd_idx),
      .wdata_i   (req_wdata_i),
      .raddr_a_i (bd_idx),
      .rdata_a_o (bd_bus_rdata),
      .raddr_b_i (bd_rd_idx_i),
      .rdata_b_o (bd_rd_data_o)
   );

   // ---------------- response ----------------
   logic [31:0] rd_val;
   logic [31:0] rdata_q;
   logic        err_q;

   always_comb begin
      rd_val = '0;
      if (bd_hit)       rd_val = bd_bus_rdata;
      else if (reg_hit) rd_val = csr_q[reg_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         rdata_q <= (req_valid_i && !req_write_i) ? rd_val : '0;
         err_q   <= req_valid_i && !(reg_hit || bd_hit);
      end
   end

   assign rsp_rdata_o = rdata_q;
   assign rsp_err_o   = err_q;

   // ---------------- outputs ----------------
   assign mode_o       = csr_q[CSR_MODE];
   assign ipg_tx_o     = csr_q[CSR_IPG_TX];
   assign ipg_rx1_o    = csr_q[CSR_IPG_RX1];
   assign ipg_rx2_o    = csr_q[CSR_IPG_RX2];
   assign frame_len_o  = csr_q[CSR_FRAME_LEN];
   assign coll_cfg_o   = csr_q[CSR_COLL];
   assign split_o      = csr_q[CSR_SPLIT][SPLIT_W-1:0];
   assign rx_bd_idx_o  = rx_idx_q;
   assign ctrl_mode_o  = csr_q[CSR_CTRL];
   assign mgmt_mode_o  = csr_q[CSR_MGMT_MODE];
   assign mgmt_cmd_o   = csr_q[CSR_MGMT_CMD];
   assign mgmt_addr_o  = csr_q[CSR_MGMT_ADDR];
   assign mgmt_wdata_o = csr_q[CSR_MGMT_WDATA];
   assign mgmt_rdata_o = csr_q[CSR_MGMT_RDATA];
   assign mgmt_stat_o  = csr_q[CSR_MGMT_STAT];
   assign station_o    = {csr_q[CSR_STN_HI][15:0], csr_q[CSR_STN_LO]};
   assign hash_o       = {csr_q[CSR_HASH_HI], csr_q[CSR_HASH_LO]};
   assign irq_src_o    = irq_src;

   // ---------------- assertions ----------------
   assert_split_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_write_i && req_addr_i == SPLIT_ADDR)
      |=> (rx_bd_idx_o == $past(req_wdata_i[SPLIT_W-1:0]) && split_o == rx_bd_idx_o));

   assert_misalign_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_addr_i[1:0] != 2'b00) |=> (rsp_err_o && rsp_rdata_o == '0));

   assert_misalign_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_addr_i[1:0] != 2'b00) |=> ($stable(mode_o) && $stable(station_o)));

   assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> (rsp_rdata_o == '0));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> (!rsp_err_o && rsp_rdata_o == '0));

   always_comb begin
      if (rst_n) assert_aligned_hit_R8: assert (aligned || !(reg_hit || bd_hit));
   end

endmodule

// File: tb/mac_csr_bank_tb.sv
`timescale 1ns/1ps
module mac_csr_bank_tb;
   localparam int ADDR_W   = 11;
   localparam int BD_BASE  = 1024;
   localparam int BD_WORDS = 64;
   localparam int IRQ_W    = 7;
   localparam int SPLIT_W  = 8;
   localparam int NREG     = 20;
   localparam int BD_AW    = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic [31:0]        req_wdata = '0;
   logic [31:0]        rsp_rdata;
   logic               rsp_err;
   logic [IRQ_W-1:0]   evt = '0;
   logic [BD_AW-1:0]   bd_rd_idx = '0;
   logic [31:0]        bd_rd_data;
   logic [31:0] mode, ipg_tx, ipg_rx1, ipg_rx2, frame_len, coll_cfg, ctrl_mode;
   logic [31:0] mgmt_mode, mgmt_cmd, mgmt_addr, mgmt_wdata, mgmt_rdata, mgmt_stat;
   logic [SPLIT_W-1:0] split, rx_bd_idx;
   logic [47:0]        station;
   logic [63:0]        hash;
   logic [IRQ_W-1:0]   irq_src;
   logic               irq;

   always #2.5 clk = ~clk;

   mac_csr_bank u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
      .rsp_err_o(rsp_err), .evt_i(evt), .bd_rd_idx_i(bd_rd_idx), .bd_rd_data_o(bd_rd_data),
      .mode_o(mode), .ipg_tx_o(ipg_tx), .ipg_rx1_o(ipg_rx1), .ipg_rx2_o(ipg_rx2),
      .frame_len_o(frame_len), .coll_cfg_o(coll_cfg), .split_o(split),
      .rx_bd_idx_o(rx_bd_idx), .ctrl_mode_o(ctrl_mode), .mgmt_mode_o(mgmt_mode),
      .mgmt_cmd_o(mgmt_cmd), .mgmt_addr_o(mgmt_addr), .mgmt_wdata_o(mgmt_wdata),
      .mgmt_rdata_o(mgmt_rdata), .mgmt_stat_o(mgmt_stat), .station_o(station),
      .hash_o(hash), .irq_src_o(irq_src), .irq_o(irq)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [31:0] shadow [NREG];
   logic [31:0] bd_shadow [BD_WORDS];
   logic [31:0] rd;
   logic        er;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rst_of(int i);
      case (i)
         0: return 32'h0000_A000;
         3: return 32'h12;
         4: return 32'h0C;
         5: return 32'h12;
         6: return 32'h003C_0600;
         7: return 32'h000F_003F;
         8: return 32'h80;
         10: return 32'h64;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] mask_of(int i);
      case (i)
         2: return 32'h7F;
         8: return 32'hFF;
         17: return 32'hFFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a[ADDR_W-1:0]; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
      e = rsp_err;
   endtask

   task automatic bus_rd(input logic [31:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a[ADDR_W-1:0];
      @(negedge clk);
      req_valid = 0;
      d = rsp_rdata; e = rsp_err;
   endtask

   task automatic pulse_evt(input logic [IRQ_W-1:0] v);
      @(negedge clk); evt = v;
      @(negedge clk); evt = '0;
   endtask

   task automatic check_regs(input string tag);
      logic [31:0] d; logic e;
      for (int i = 0; i < NREG; i++) begin
         if (i != 1) begin
            bus_rd(32'(i * 4), d, e);
            chk($sformatf("%s reg%0d", tag, i), {32'h0, d}, {32'h0, shadow[i]});
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int i = 0; i < NREG; i++) shadow[i] = rst_of(i);
      chk("R1 rx_bd_idx", 64'(rx_bd_idx), 64'h80);
      chk("R1 irq", 64'(irq), 64'h0);
      chk("R1 mode port", 64'(mode), 64'hA000);
      chk("R1 mgmt mode port", 64'(mgmt_mode), 64'h64);
      check_regs("R1");
      bus_rd(32'h04, rd, er);
      chk("R1 irq src", 64'(rd), 64'h0);

      // R10 idle response and latency
      chk("R10 idle rdata", 64'(rsp_rdata), 64'h0);
      chk("R10 idle err", 64'(rsp_err), 64'h0);
      bus_rd(32'h18, rd, er);
      chk("R10 read latency", {31'h0, er, rd}, {32'h0, 32'h003C_0600});

      // R10 full register sweep
      for (int i = 0; i < NREG; i++) begin
         if (i != 1) begin
            logic [31:0] d;
            d = 32'hA55A_3CC3 ^ (32'(i) * 32'h0103_0507) ^ (32'h1 << i);
            bus_wr(32'(i * 4), d, er);
            shadow[i] = d & mask_of(i);
         end
      end
      check_regs("R10");
      chk("R10 mode port", 64'(mode), 64'(shadow[0]));
      chk("R10 coll port", 64'(coll_cfg), 64'(shadow[7]));
      chk("R10 mgmt stat port", 64'(mgmt_stat), 64'(shadow[15]));
      chk("R10 hash port", hash, {shadow[19], shadow[18]});

      // R5 split register
      bus_wr(32'h20, 32'h1234_56C3, er);
      shadow[8] = 32'hC3;
      chk("R5 rx index", 64'(rx_bd_idx), 64'hC3);
      chk("R5 split port", 64'(split), 64'hC3);
      bus_rd(32'h20, rd, er);
      chk("R5 split read", 64'(rd), 64'hC3);
      bus_wr(32'h20, 32'hFFFF_FF00, er);
      shadow[8] = 32'h0;
      chk("R5 rx index zero", 64'(rx_bd_idx), 64'h0);

      // R6 station address packing
      bus_wr(32'h40, 32'h4433_2211, er);
      bus_wr(32'h44, 32'hFFFF_6655, er);
      shadow[16] = 32'h4433_2211; shadow[17] = 32'h6655;
      chk("R6 station", 64'(station), 64'h6655_4433_2211);
      bus_rd(32'h44, rd, er);
      chk("R6 station hi read", 64'(rd), 64'h6655);

      // R2 write-one-to-clear, every clear pattern
      bus_wr(32'h08, 32'h0, er);
      shadow[2] = 32'h0;
      for (int v = 0; v < 128; v++) begin
         pulse_evt(7'h7F);
         bus_wr(32'h04, 32'(v) | 32'hFFFF_FF00 & 32'h0, er);
         bus_rd(32'h04, rd, er);
         chk($sformatf("R2 clear %0h", v), 64'(rd), 64'(7'h7F & ~7'(v)));
      end
      bus_wr(32'h04, 32'hFFFF_FFFF, er);
      chk("R2 clear all port", 64'(irq_src), 64'h0);

      // R3 set wins over clear
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 11'h004; req_wdata = 32'hFFFF_FFFF; evt = 7'h09;
      @(negedge clk);
      req_valid = 0; req_write = 0; evt = '0;
      chk("R3 set wins", 64'(irq_src), 64'h09);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 11'h004; req_wdata = 32'h1; evt = 7'h01;
      @(negedge clk);
      req_valid = 0; req_write = 0; evt = '0;
      chk("R3 same bit", 64'(irq_src), 64'h09);
      pulse_evt(7'h40);
      chk("R3 event sets", 64'(irq_src), 64'h49);

      // R4 interrupt against every mask value
      bus_wr(32'h04, 32'h7F, er);
      pulse_evt(7'h55);
      for (int m = 0; m < 128; m++) begin
         bus_wr(32'h08, 32'(m), er);
         chk($sformatf("R4 mask %0h", m), 64'(irq), 64'(|(7'h55 & 7'(m))));
      end
      shadow[2] = 32'h7F;
      bus_wr(32'h04, 32'h7F, er);
      chk("R4 no source", 64'(irq), 64'h0);

      // R7 descriptor window
      for (int w = 0; w < BD_WORDS; w++) begin
         bd_shadow[w] = (32'(w) * 32'h9E37_79B9) ^ 32'h0F0F_0F0F;
         bus_wr(32'(BD_BASE + 4 * w), bd_shadow[w], er);
      end
      for (int w = 0; w < BD_WORDS; w++) begin
         bus_rd(32'(BD_BASE + 4 * w), rd, er);
         chk($sformatf("R7 bus word %0d", w), {31'h0, er, rd}, {32'h0, bd_shadow[w]});
         bd_rd_idx = 6'(BD_WORDS - 1 - w);
         #0.1;
         chk($sformatf("R7 engine word %0d", BD_WORDS - 1 - w), 64'(bd_rd_data),
             64'(bd_shadow[BD_WORDS - 1 - w]));
      end

      // R8 misaligned
      bus_wr(32'h001, 32'hDEAD_BEEF, er);
      chk("R8 write err", 64'(er), 64'h1);
      bus_wr(32'h402, 32'hDEAD_BEEF, er);
      chk("R8 bd write err", 64'(er), 64'h1);
      bus_rd(32'h002, rd, er);
      chk("R8 read", {31'h0, er, rd}, {31'h0, 1'b1, 32'h0});
      bus_rd(32'h403, rd, er);
      chk("R8 bd read", {31'h0, er, rd}, {31'h0, 1'b1, 32'h0});
      bus_rd(32'h400, rd, er);
      chk("R8 bd word kept", 64'(rd), 64'(bd_shadow[0]));
      check_regs("R8");

      // R9 unmapped
      bus_rd(32'h050, rd, er);
      chk("R9 gap read", {31'h0, er, rd}, {31'h0, 1'b1, 32'h0});
      bus_rd(32'h3FC, rd, er);
      chk("R9 below window", {31'h0, er, rd}, {31'h0, 1'b1, 32'h0});
      bus_rd(32'h500, rd, er);
      chk("R9 above window", {31'h0, er, rd}, {31'h0, 1'b1, 32'h0});
      bus_wr(32'h060, 32'hFFFF_FFFF, er);
      chk("R9 write err", 64'(er), 64'h1);
      bus_wr(32'h7FC, 32'hFFFF_FFFF, er);
      chk("R9 top write err", 64'(er), 64'h1);
      check_regs("R9");
      bus_rd(32'h4FC, rd, er);
      chk("R9 last word kept", {31'h0, er, rd}, {32'h0, bd_shadow[BD_WORDS - 1]});
      chk("R9 rx index kept", 64'(rx_bd_idx), 64'h0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule